// File: doc/BRIEF.md
# L1 Line Maintenance Engine

This block carries out maintenance commands against a small direct-mapped L1 tag and state array. Each line keeps a tag, a valid bit, a dirty bit and a class bit that marks the line as local or global. A requester presents one command at a time. The single-line commands are write-back, invalidate and discard, and each one selects its line by address. The two sweep commands invalidate every line of one class. The engine answers each command with a one-cycle done pulse.

When a dirty line has to reach the next level, the engine raises a write-back request that carries the line index and the tag. It holds that request until the next level accepts it. The data array and the refill logic are outside this block. The array has a fill port so that the surrounding cache can install lines. It also has a combinational probe port that shows the stored state of any line.

A command line address is `{tag, index}`, with the tag in the upper TAG_W bits and the index in the lower INDEX_W bits. The command codes are 0 write-back, 1 invalidate, 2 discard, 3 global sweep and 4 local sweep. Codes 5 to 7 are reserved.

Top module: `l1_maint_engine`

## Requirements
- R1: Write-back (code 0) on a hit to a dirty line raises exactly one write-back request that carries that line's index and tag. Once the request is accepted, the dirty bit is clear and the line is still valid. A hit to a clean line issues no request.
- R2: Invalidate (code 1) on a hit to a dirty line first issues a write-back request and clears the valid bit only after that request is accepted. A hit to a clean line clears the valid bit without any request.
- R3: Discard (code 2) on a hit clears both the valid bit and the dirty bit and issues no write-back request, even when the line is dirty.
- R4: A single-line command that misses (the line is invalid or its tag differs), and any reserved code (5 to 7), pulses done in the first cycle after acceptance. It changes no line and issues no write-back.
- R5: Global sweep (code 3) clears the valid bit of every valid global line (class bit 0) and issues no write-back, even for dirty lines. Local lines keep their state.
- R6: Local sweep (code 4) clears every valid local line (class bit 1). It writes back each dirty local line first, in ascending index order. Global lines keep their state.
- R7: A sweep visits one line per cycle starting at index 0. With no write-backs, done pulses in cycle 2^INDEX_W after acceptance.
- R8: A write-back request keeps its index and tag stable until it is accepted. Done is never asserted while a request is still waiting for acceptance.
- R9: cmdReady is high only while the engine is idle. A command presented while the engine is busy is ignored.
- R10: Done is a single-cycle pulse.
- R11: After reset every line is invalid and clean, cmdReady is high, and wbValid and donePulse are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdValid | input | 1 | Command present |
| cmdReady | output | 1 | Engine idle and able to take a command |
| cmdOp | input | 3 | Command code |
| cmdLineAddr | input | TAG_W+INDEX_W | Line address `{tag, index}` for single-line commands |
| donePulse | output | 1 | One-cycle completion pulse |
| wbValid | output | 1 | Write-back request to the next level |
| wbReady | input | 1 | Next level accepts the write-back |
| wbIndex | output | INDEX_W | Index of the line being written back |
| wbTag | output | TAG_W | Tag of the line being written back |
| fillEn | input | 1 | Install a line (must be idle) |
| fillIndex | input | INDEX_W | Index to install |
| fillTag | input | TAG_W | Tag to install |
| fillDirty | input | 1 | Dirty state of the installed line |
| fillLocal | input | 1 | Class of the installed line (1 local, 0 global) |
| probeIndex | input | INDEX_W | Line to observe |
| probeValid | output | 1 | Valid bit of the probed line |
| probeDirty | output | 1 | Dirty bit of the probed line |
| probeLocal | output | 1 | Class bit of the probed line |
| probeTag | output | TAG_W | Tag of the probed line |

## Verification
The assertions watch, on every cycle, that a pending write-back request holds its index and tag and points at a valid dirty line. They also check that done never coincides with an unaccepted request, that done lasts one cycle, and that cmdReady drops right after an acceptance. Only the bench scenarios can show which lines each command changes: the per-command treatment of dirty lines, the class filter of the sweeps, the order of sweep write-backs, the miss and reserved-code timing, and that a command offered while busy leaves the array untouched.

// File: rtl/l1m_pkg.sv
package l1m_pkg;

  typedef enum logic [2:0] {
    OP_WRITEBACK  = 3'd0,
    OP_INVAL      = 3'd1,
    OP_DISCARD    = 3'd2,
    OP_SWEEP_GLB  = 3'd3,
    OP_SWEEP_LCL  = 3'd4
  } maintOp_e;

  typedef enum logic [1:0] {
    S_IDLE,
    S_EXEC,
    S_WALK,
    S_WBWAIT
  } engState_e;

  // control -> array update strobes
  typedef struct packed {
    logic clrValid;
    logic clrDirty;
  } lineStrobe_t;

  // array -> control view of the addressed line
  typedef struct packed {
    logic valid;
    logic dirty;
    logic isLocal;
    logic hit;
  } lineStatus_t;

endpackage

// File: rtl/l1m_lines.sv
module l1m_lines
  import l1m_pkg::*;
#(
  parameter int INDEX_W = 3,
  parameter int TAG_W   = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               fillEn,
  input  logic [INDEX_W-1:0] fillIndex,
  input  logic [TAG_W-1:0]   fillTag,
  input  logic               fillDirty,
  input  logic               fillLocal,
  input  logic [INDEX_W-1:0] lineIdx,
  input  logic [TAG_W-1:0]   cmpTag,
  input  lineStrobe_t        strb,
  output lineStatus_t        stat,
  output logic [TAG_W-1:0]   curTag,
  input  logic [INDEX_W-1:0] probeIndex,
  output logic               probeValid,
  output logic               probeDirty,
  output logic               probeLocal,
  output logic [TAG_W-1:0]   probeTag
);

  localparam int LINES = 1 << INDEX_W;

  logic [LINES-1:0] validVec;
  logic [LINES-1:0] dirtyVec;
  logic [LINES-1:0] localVec;
  logic [TAG_W-1:0] tagArr [LINES];

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic             lineValid;
    logic             lineDirty;
    logic             lineLocal;
    logic [TAG_W-1:0] lineTag;
    logic             fillSel;
    logic             maintSel;

    assign fillSel  = fillEn && (fillIndex == INDEX_W'(g));
    assign maintSel = (lineIdx == INDEX_W'(g));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        lineValid <= 1'b0;
        lineDirty <= 1'b0;
        lineLocal <= 1'b0;
        lineTag   <= '0;
      end else begin
        if (fillSel) begin
          lineValid <= 1'b1;
          lineDirty <= fillDirty;
          lineLocal <= fillLocal;
          lineTag   <= fillTag;
        end
        // maintenance update wins over a same-cycle fill
        if (maintSel && strb.clrValid) lineValid <= 1'b0;
        if (maintSel && strb.clrDirty) lineDirty <= 1'b0;
      end
    end

    assign validVec[g] = lineValid;
    assign dirtyVec[g] = lineDirty;
    assign localVec[g] = lineLocal;
    assign tagArr[g]   = lineTag;
  end

  always_comb begin
    stat.valid   = validVec[lineIdx];
    stat.dirty   = dirtyVec[lineIdx];
    stat.isLocal = localVec[lineIdx];
    stat.hit     = validVec[lineIdx] && (tagArr[lineIdx] == cmpTag);
    curTag       = tagArr[lineIdx];
  end

  assign probeValid = validVec[probeIndex];
  assign probeDirty = dirtyVec[probeIndex];
  assign probeLocal = localVec[probeIndex];
  assign probeTag   = tagArr[probeIndex];

endmodule

// File: rtl/l1m_ctrl.sv
module l1m_ctrl
  import l1m_pkg::*;
#(
  parameter int INDEX_W = 3,
  parameter int TAG_W   = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cmdValid,
  output logic               cmdReady,
  input  logic [2:0]         cmdOp,
  input  logic [TAG_W-1:0]   cmdTag,
  input  logic [INDEX_W-1:0] cmdIdx,
  output logic               donePulse,
  output logic               wbValid,
  input  logic               wbReady,
  output logic [INDEX_W-1:0] wbIndex,
  output logic [TAG_W-1:0]   wbTag,
  output logic [INDEX_W-1:0] lineIdx,
  output logic [TAG_W-1:0]   cmpTag,
  output lineStrobe_t        strb,
  input  lineStatus_t        stat,
  input  logic [TAG_W-1:0]   curTag
);

  localparam logic [INDEX_W-1:0] LAST_IDX = '1;

  engState_e          state, stateNxt;
  logic [2:0]         opQ;
  logic [TAG_W-1:0]   tagQ;
  logic [INDEX_W-1:0] idxQ, idxNxt;
  logic               cmdIsSweep;
  logic               opIsSweep;
  logic               classMatch;

  assign cmdIsSweep = (cmdOp == OP_SWEEP_GLB) || (cmdOp == OP_SWEEP_LCL);
  assign opIsSweep  = (opQ == OP_SWEEP_GLB) || (opQ == OP_SWEEP_LCL);
  assign classMatch = stat.valid && (stat.isLocal == (opQ == OP_SWEEP_LCL));

  always_comb begin
    stateNxt  = state;
    idxNxt    = idxQ;
    strb      = '0;
    donePulse = 1'b0;
    wbValid   = 1'b0;
    unique case (state)
      S_IDLE: begin
        if (cmdValid) begin
          stateNxt = cmdIsSweep ? S_WALK : S_EXEC;
          idxNxt   = cmdIsSweep ? '0 : cmdIdx;
        end
      end
      S_EXEC: begin
        stateNxt  = S_IDLE;
        donePulse = 1'b1;
        if (opQ == OP_WRITEBACK || opQ == OP_INVAL) begin
          if (stat.hit && stat.dirty) begin
            stateNxt  = S_WBWAIT;
            donePulse = 1'b0;
          end else if (stat.hit && opQ == OP_INVAL) begin
            strb.clrValid = 1'b1;
          end
        end else if (opQ == OP_DISCARD && stat.hit) begin
          strb.clrValid = 1'b1;
          strb.clrDirty = 1'b1;
        end
      end
      S_WALK: begin
        if (classMatch && stat.dirty && opQ == OP_SWEEP_LCL) begin
          stateNxt = S_WBWAIT;
        end else begin
          if (classMatch) begin
            strb.clrValid = 1'b1;
            strb.clrDirty = 1'b1;
          end
          if (idxQ == LAST_IDX) begin
            stateNxt  = S_IDLE;
            donePulse = 1'b1;
          end else begin
            idxNxt = idxQ + 1'b1;
          end
        end
      end
      S_WBWAIT: begin
        wbValid = 1'b1;
        if (wbReady) begin
          strb.clrDirty = 1'b1;
          strb.clrValid = (opQ != OP_WRITEBACK);
          if (opIsSweep && idxQ != LAST_IDX) begin
            stateNxt = S_WALK;
            idxNxt   = idxQ + 1'b1;
          end else begin
            stateNxt  = S_IDLE;
            donePulse = 1'b1;
          end
        end
      end
      default: stateNxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
      opQ   <= '0;
      tagQ  <= '0;
      idxQ  <= '0;
    end else begin
      state <= stateNxt;
      idxQ  <= idxNxt;
      if (state == S_IDLE && cmdValid) begin
        opQ  <= cmdOp;
        tagQ <= cmdTag;
      end
    end
  end

  assign cmdReady = (state == S_IDLE);
  assign lineIdx  = idxQ;
  assign cmpTag   = tagQ;
  assign wbIndex  = idxQ;
  assign wbTag    = curTag;

  // R10
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |=> !donePulse);

  // R8
  wb_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wbValid && !wbReady) |=> (wbValid && $stable(wbIndex) && $stable(wbTag)));

  // R8
  done_after_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |-> !(wbValid && !wbReady));

  // R9
  busy_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdReady) |=> !cmdReady);

  // R1
  wb_dirty_chk: assert property (@(posedge clk) disable iff (!rstN)
    wbValid |-> (stat.valid && stat.dirty));

endmodule

// File: rtl/l1_maint_engine.sv
module l1_maint_engine
  import l1m_pkg::*;
#(
  parameter int INDEX_W = 3,
  parameter int TAG_W   = 8,
  localparam int LADDR_W = TAG_W + INDEX_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cmdValid,
  output logic               cmdReady,
  input  logic [2:0]         cmdOp,
  input  logic [LADDR_W-1:0] cmdLineAddr,
  output logic               donePulse,
  output logic               wbValid,
  input  logic               wbReady,
  output logic [INDEX_W-1:0] wbIndex,
  output logic [TAG_W-1:0]   wbTag,
  input  logic               fillEn,
  input  logic [INDEX_W-1:0] fillIndex,
  input  logic [TAG_W-1:0]   fillTag,
  input  logic               fillDirty,
  input  logic               fillLocal,
  input  logic [INDEX_W-1:0] probeIndex,
  output logic               probeValid,
  output logic               probeDirty,
  output logic               probeLocal,
  output logic [TAG_W-1:0]   probeTag
);

  logic [INDEX_W-1:0] lineIdx;
  logic [TAG_W-1:0]   cmpTag;
  logic [TAG_W-1:0]   curTag;
  lineStrobe_t        strb;
  lineStatus_t        stat;

  l1m_ctrl #(.INDEX_W(INDEX_W), .TAG_W(TAG_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .cmdValid  (cmdValid),
    .cmdReady  (cmdReady),
    .cmdOp     (cmdOp),
    .cmdTag    (cmdLineAddr[LADDR_W-1 -: TAG_W]),
    .cmdIdx    (cmdLineAddr[INDEX_W-1:0]),
    .donePulse (donePulse),
    .wbValid   (wbValid),
    .wbReady   (wbReady),
    .wbIndex   (wbIndex),
    .wbTag     (wbTag),
    .lineIdx   (lineIdx),
    .cmpTag    (cmpTag),
    .strb      (strb),
    .stat      (stat),
    .curTag    (curTag)
  );

  l1m_lines #(.INDEX_W(INDEX_W), .TAG_W(TAG_W)) u_lines (
    .clk        (clk),
    .rstN       (rstN),
    .fillEn     (fillEn),
    .fillIndex  (fillIndex),
    .fillTag    (fillTag),
    .fillDirty  (fillDirty),
    .fillLocal  (fillLocal),
    .lineIdx    (lineIdx),
    .cmpTag     (cmpTag),
    .strb       (strb),
    .stat       (stat),
    .curTag     (curTag),
    .probeIndex (probeIndex),
    .probeValid (probeValid),
    .probeDirty (probeDirty),
    .probeLocal (probeLocal),
    .probeTag   (probeTag)
  );

endmodule

// File: tb/l1_maint_engine_test.sv
`timescale 1ns/1ps
module l1_maint_engine_test;

  localparam int INDEX_W = 3;
  localparam int TAG_W   = 8;
  localparam int LADDR_W = TAG_W + INDEX_W;
  localparam int LINES   = 1 << INDEX_W;

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic               cmdValid = 1'b0;
  logic               cmdReady;
  logic [2:0]         cmdOp = '0;
  logic [LADDR_W-1:0] cmdLineAddr = '0;
  logic               donePulse;
  logic               wbValid;
  logic               wbReady = 1'b0;
  logic [INDEX_W-1:0] wbIndex;
  logic [TAG_W-1:0]   wbTag;
  logic               fillEn = 1'b0;
  logic [INDEX_W-1:0] fillIndex = '0;
  logic [TAG_W-1:0]   fillTag = '0;
  logic               fillDirty = 1'b0;
  logic               fillLocal = 1'b0;
  logic [INDEX_W-1:0] probeIndex = '0;
  logic               probeValid, probeDirty, probeLocal;
  logic [TAG_W-1:0]   probeTag;

  int vectors = 0;
  int miscompares = 0;
  int wbDelay = 0;
  int stallCnt = 0;
  int wbCount = 0;
  int doneWhilePending = 0;
  logic [INDEX_W-1:0] wbIdxLog [16];
  logic [TAG_W-1:0]   wbTagLog [16];

  always #10 clk = ~clk;

  l1_maint_engine #(.INDEX_W(INDEX_W), .TAG_W(TAG_W)) uut (.*);

  // next-level responder
  always @(negedge clk) begin
    if (wbReady) begin
      wbReady  <= 1'b0;
      stallCnt <= 0;
    end else if (!wbValid) begin
      stallCnt <= 0;
    end else if (stallCnt >= wbDelay) begin
      wbReady <= 1'b1;
    end else begin
      stallCnt <= stallCnt + 1;
    end
  end

  always @(posedge clk) begin
    if (wbValid && wbReady) begin
      if (wbCount < 16) begin
        wbIdxLog[wbCount] <= wbIndex;
        wbTagLog[wbCount] <= wbTag;
      end
      wbCount <= wbCount + 1;
    end
    if (donePulse && wbValid && !wbReady) doneWhilePending <= doneWhilePending + 1;
  end

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [LADDR_W-1:0] la(input int tag, input int idx);
    return {TAG_W'(tag), INDEX_W'(idx)};
  endfunction

  task automatic fill(input int idx, input int tag, input bit dirty, input bit isLocal);
    @(negedge clk);
    fillEn = 1'b1; fillIndex = INDEX_W'(idx); fillTag = TAG_W'(tag);
    fillDirty = dirty; fillLocal = isLocal;
    @(negedge clk);
    fillEn = 1'b0;
  endtask

  task automatic probe(input int idx, output bit v, output bit d, output bit l, output int t);
    probeIndex = INDEX_W'(idx);
    #1;
    v = probeValid; d = probeDirty; l = probeLocal; t = int'(probeTag);
  endtask

  // issue a command, return cycles from acceptance to done
  task automatic doCmd(input int op, input logic [LADDR_W-1:0] a, output int n);
    @(negedge clk);
    while (!cmdReady) @(negedge clk);
    cmdValid = 1'b1; cmdOp = 3'(op); cmdLineAddr = a;
    @(negedge clk);
    cmdValid = 1'b0;
    n = 1;
    while (!donePulse && n < 500) begin
      @(negedge clk);
      n++;
    end
    @(negedge clk);
    chk("R10 done width", int'(donePulse), 0);
  endtask

  task automatic testReset();
    bit v, d, l; int t;
    chk("R11 cmdReady", int'(cmdReady), 1);
    chk("R11 wbValid", int'(wbValid), 0);
    chk("R11 donePulse", int'(donePulse), 0);
    for (int i = 0; i < LINES; i++) begin
      probe(i, v, d, l, t);
      chk("R11 line valid", int'(v), 0);
      chk("R11 line dirty", int'(d), 0);
    end
  endtask

  task automatic testWriteback();
    bit v, d, l; int t, n, base;
    wbDelay = 2;
    fill(1, 8'h21, 1'b1, 1'b0);
    base = wbCount;
    doCmd(0, la(8'h21, 1), n);
    chk("R1 wb count", wbCount - base, 1);
    chk("R1 wb index", int'(wbIdxLog[base]), 1);
    chk("R1 wb tag", int'(wbTagLog[base]), 8'h21);
    probe(1, v, d, l, t);
    chk("R1 stays valid", int'(v), 1);
    chk("R1 dirty cleared", int'(d), 0);
    base = wbCount;
    doCmd(0, la(8'h21, 1), n);
    chk("R1 clean hit no wb", wbCount - base, 0);
    chk("R8 no done while pending", doneWhilePending, 0);
  endtask

  task automatic testMiss();
    bit v, d, l; int t, n, base;
    fill(3, 8'h30, 1'b1, 1'b0);
    base = wbCount;
    doCmd(1, la(8'h31, 3), n);
    chk("R4 miss latency", n, 1);
    chk("R4 miss no wb", wbCount - base, 0);
    probe(3, v, d, l, t);
    chk("R4 miss line valid", int'(v), 1);
    chk("R4 miss line dirty", int'(d), 1);
    doCmd(2, la(8'h55, 0), n);
    chk("R4 invalid line miss latency", n, 1);
    doCmd(6, la(8'h30, 3), n);
    chk("R4 reserved latency", n, 1);
    probe(3, v, d, l, t);
    chk("R4 reserved no change", int'(v && d), 1);
  endtask

  task automatic testInvalidate();
    bit v, d, l; int t, n, base;
    wbDelay = 1;
    base = wbCount;
    doCmd(1, la(8'h30, 3), n);
    chk("R2 dirty wb count", wbCount - base, 1);
    chk("R2 dirty wb tag", int'(wbTagLog[base]), 8'h30);
    probe(3, v, d, l, t);
    chk("R2 dirty invalid", int'(v), 0);
    fill(4, 8'h44, 1'b0, 1'b0);
    base = wbCount;
    doCmd(1, la(8'h44, 4), n);
    chk("R2 clean no wb", wbCount - base, 0);
    chk("R2 clean latency", n, 1);
    probe(4, v, d, l, t);
    chk("R2 clean invalid", int'(v), 0);
  endtask

  task automatic testDiscard();
    bit v, d, l; int t, n, base;
    fill(5, 8'h5A, 1'b1, 1'b1);
    base = wbCount;
    doCmd(2, la(8'h5A, 5), n);
    chk("R3 no wb", wbCount - base, 0);
    probe(5, v, d, l, t);
    chk("R3 invalid", int'(v), 0);
    chk("R3 clean", int'(d), 0);
  endtask

  task automatic fillAll();
    // even global, odd local; dirty at 0, 1, 2, 5, 7
    for (int i = 0; i < LINES; i++)
      fill(i, 8'h80 + i, (i == 0 || i == 1 || i == 2 || i == 5 || i == 7), i[0]);
  endtask

  task automatic testSweepGlobal();
    bit v, d, l; int t, n, base;
    fillAll();
    base = wbCount;
    doCmd(3, '0, n);
    chk("R7 walk latency", n, LINES);
    chk("R5 no wb", wbCount - base, 0);
    for (int i = 0; i < LINES; i++) begin
      probe(i, v, d, l, t);
      chk("R5 class filter", int'(v), i % 2);
    end
  endtask

  task automatic testSweepLocal();
    bit v, d, l; int t, n, base;
    wbDelay = 3;
    fillAll();
    base = wbCount;
    doCmd(4, '0, n);
    chk("R6 wb count", wbCount - base, 3);
    chk("R6 order 0", int'(wbIdxLog[base]), 1);
    chk("R6 order 1", int'(wbIdxLog[base + 1]), 5);
    chk("R6 order 2", int'(wbIdxLog[base + 2]), 7);
    chk("R6 tag", int'(wbTagLog[base + 1]), 8'h85);
    chk("R8 no done while pending", doneWhilePending, 0);
    for (int i = 0; i < LINES; i++) begin
      probe(i, v, d, l, t);
      chk("R6 class filter", int'(v), 1 - (i % 2));
    end
    probe(2, v, d, l, t);
    chk("R6 global dirty kept", int'(d), 1);
  endtask

  task automatic testBusyIgnore();
    bit v, d, l; int t, n;
    wbDelay = 6;
    fill(2, 8'h42, 1'b1, 1'b0);
    fill(6, 8'h66, 1'b0, 1'b0);
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = 3'd0; cmdLineAddr = la(8'h42, 2);
    @(negedge clk);
    cmdOp = 3'd2; cmdLineAddr = la(8'h66, 6);
    for (int k = 0; k < 3; k++) begin
      chk("R9 ready low while busy", int'(cmdReady), 0);
      @(negedge clk);
    end
    cmdValid = 1'b0;
    n = 0;
    while (!donePulse && n < 500) begin
      @(negedge clk);
      n++;
    end
    @(negedge clk);
    chk("R9 ready after done", int'(cmdReady), 1);
    probe(6, v, d, l, t);
    chk("R9 busy command ignored", int'(v), 1);
  endtask

  initial begin
    #(20 * 150000);
    miscompares++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testWriteback();
    testMiss();
    testInvalidate();
    testDiscard();
    testSweepGlobal();
    testSweepLocal();
    testBusyIgnore();
    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule